// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects interrupt lines from a configurable number of 32-wide source banks (three by default, 96 sources) and raises a single registered request towards the processor. Software reaches it through a plain 32-bit register port. The port has a write strobe, a byte address and a read path that returns data in the same cycle. Per bank there is a pending view, an enable word and a mask word. A source counts as active only when it is pending, its enable bit is 1 and its mask bit is 0.

Every source except source 0 is level-following: its pending bit is simply the current input line, and it goes away when the line drops. Source 0 is an external line with a selectable trigger. It is captured into a sticky pending flag, and software clears that flag by writing 1 to bit 0 of the first pending word. A vector word reports the lowest-numbered active source, shifted left by two. It reads zero both when nothing is active and when source 0 is the winner, so a handler reads pending bit 0 to tell these two cases apart. A one-bit protection control and the trigger selection for source 0 complete the map.

Top module: `birq_top`

## Requirements
- R1: After reset all enable words, all mask words, the protection bit and the trigger field read 0, and `irq_o` is 0.
- R2: Source n sits at bit n%32 of bank n/32. For bank k, the pending word is at byte offset 0x10+4k, the enable word at 0x40+4k and the mask word at 0x50+4k.
- R3: For every source n other than 0, the pending bit reads the current input level in the same cycle. Writing 1 to such a bit has no effect.
- R4: `irq_o` is 1 in the cycle after some source is pending, enabled (enable bit 1) and unmasked (mask bit 0). Otherwise it is 0. A set mask bit blocks an enabled source.
- R5: The word at offset 0x00 reads (index of the lowest-numbered active source) << 2, and reads 0 when no source is active.
- R6: Bits [1:0] at offset 0x0C select the trigger for source 0: 0 = input low, 1 = input high, 2 = falling edge, 3 = rising edge. The pending flag of source 0 sets on the clock edge at which the condition is seen, and it holds after the condition goes away.
- R7: Writing a word with bit 0 = 1 to offset 0x10 clears the source-0 pending flag. Writing bit 0 = 0 leaves it unchanged. If the trigger condition is present in the same cycle as the clearing write, the flag stays set.
- R8: Bit 0 at offset 0x08 is a read/write protection control, and its other bits read 0. Bits [1:0] at offset 0x0C are read/write, and its other bits read 0.
- R9: Reads of unmapped or misaligned offsets return 0. Writes to them, and writes to the vector word, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 96 | Interrupt source lines, index = source number |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, same cycle |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Two events can land on the same clock edge: the trigger of source 0 setting its pending flag, and the software acknowledge write clearing that flag. The bench provokes this in falling-edge mode by dropping the source-0 line on the same negative edge at which it starts the clearing write. After that edge the pending bit must read 1. It does the same in high-level mode, with the line still high during the acknowledge. In both cases the bench then repeats the acknowledge with the condition absent, and the bit must read 0.

// File: rtl/birq_pkg.sv
// Package: shared offsets and the trigger encoding of the banked interrupt controller.
// Assumes byte addressing with word-aligned registers.
package birq_pkg;
    localparam int unsigned REG_W     = 32;
    localparam logic [7:0]  OFF_VEC   = 8'h00;
    localparam logic [7:0]  OFF_PROT  = 8'h08;
    localparam logic [7:0]  OFF_XCTL  = 8'h0C;
    localparam logic [7:0]  OFF_PEND  = 8'h10;
    localparam logic [7:0]  OFF_EN    = 8'h40;
    localparam logic [7:0]  OFF_MSK   = 8'h50;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;
endpackage

// File: rtl/birq_src0_latch.sv
// Module: sticky pending flag for the external source 0.
// Sets on the selected level or edge; cleared by an acknowledge pulse.
// A set condition in the same cycle as the acknowledge wins.
module birq_src0_latch
    import birq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src,
    input  trig_e      trig,
    input  logic       ack,
    output logic       pend
);
    logic prev_q;
    logic set_now;

    // Trigger condition for the selected mode.
    always_comb begin
        unique case (trig)
            TRIG_LOW:  set_now = ~src;
            TRIG_HIGH: set_now = src;
            TRIG_FALL: set_now = prev_q & ~src;
            default:   set_now = ~prev_q & src;
        endcase
    end

    // Previous input sample for the edge modes.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    // Sticky flag: set has priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (set_now) pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end

    AST_SRC0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !ack |=> pend);  // R6
    AST_SRC0_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !set_now |=> !pend);  // R7
    AST_SRC0_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_RISE) && src && !$past(src) && $past(rst_n) |=> pend);  // R6
endmodule

// File: rtl/birq_cfg_regs.sv
// Module: enable and mask words per bank, the protection bit and the trigger field.
// Each write strobe is decoded by the parent; all fields reset to 0.
module birq_cfg_regs
    import birq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    localparam int unsigned NSRC = NUM_BANKS * REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] en_we,
    input  logic [NUM_BANKS-1:0] msk_we,
    input  logic                 prot_we,
    input  logic                 xctl_we,
    input  logic [REG_W-1:0]     wdata,
    output logic [NSRC-1:0]      en,
    output logic [NSRC-1:0]      msk,
    output logic                 prot,
    output trig_e                trig
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Enable and mask word of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[b*REG_W +: REG_W]  <= '0;
                msk[b*REG_W +: REG_W] <= '0;
            end else begin
                if (en_we[b])  en[b*REG_W +: REG_W]  <= wdata;
                if (msk_we[b]) msk[b*REG_W +: REG_W] <= wdata;
            end
        end
    end

    // Protection bit and source-0 trigger field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= 1'b0;
            trig <= TRIG_LOW;
        end else begin
            if (prot_we) prot <= wdata[0];
            if (xctl_we) trig <= trig_e'(wdata[1:0]);
        end
    end

    AST_PROT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_we |=> $stable(prot));  // R8
    AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we == '0) |=> $stable(en));  // R9
endmodule

// File: rtl/birq_prio_enc.sv
// Module: lowest-index picker over the active-source vector.
// Purely combinational; idx is 0 when nothing is found.
module birq_prio_enc #(
    parameter int unsigned N = 96,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/birq_top.sv
// Module: banked vectored interrupt controller top.
// Decodes the register port, forms pending/active vectors and registers the request.
// Assumes addr_i is a byte offset; reads are combinational.
module birq_top
    import birq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned NSRC  = NUM_BANKS * REG_W,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    logic [NUM_BANKS-1:0] en_we, msk_we;
    logic                 prot_we, xctl_we, ack0;
    logic [NSRC-1:0]      en, msk, pend, act;
    logic                 prot, pend0;
    trig_e                trig;
    logic                 vec_found;
    logic [IDX_W-1:0]     vec_idx;

    // Write strobe decode per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign en_we[b]  = wr_en_i && addr_i == ADDR_W'(OFF_EN)  + ADDR_W'(4 * b);
        assign msk_we[b] = wr_en_i && addr_i == ADDR_W'(OFF_MSK) + ADDR_W'(4 * b);
    end
    assign prot_we = wr_en_i && addr_i == ADDR_W'(OFF_PROT);
    assign xctl_we = wr_en_i && addr_i == ADDR_W'(OFF_XCTL);
    assign ack0    = wr_en_i && addr_i == ADDR_W'(OFF_PEND) && wdata_i[0];

    birq_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .msk_we(msk_we),
        .prot_we(prot_we), .xctl_we(xctl_we), .wdata(wdata_i),
        .en(en), .msk(msk), .prot(prot), .trig(trig)
    );

    birq_src0_latch u_src0 (
        .clk(clk), .rst_n(rst_n), .src(src_i[0]), .trig(trig),
        .ack(ack0), .pend(pend0)
    );

    assign pend = {src_i[NSRC-1:1], pend0};
    assign act  = pend & en & ~msk;

    birq_prio_enc #(.N(NSRC)) u_pick (
        .req(act), .found(vec_found), .idx(vec_idx)
    );

    // Registered request towards the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |act;
    end

    // Combinational read mux; unmapped or misaligned offsets read 0.
    always_comb begin
        rdata_o = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i == ADDR_W'(OFF_VEC))  rdata_o = REG_W'({vec_idx, 2'b00});
            if (addr_i == ADDR_W'(OFF_PROT)) rdata_o = REG_W'(prot);
            if (addr_i == ADDR_W'(OFF_XCTL)) rdata_o = REG_W'(trig);
            for (int b = 0; b < int'(NUM_BANKS); b++) begin
                if (addr_i == ADDR_W'(OFF_PEND) + ADDR_W'(4 * b)) rdata_o = pend[b*REG_W +: REG_W];
                if (addr_i == ADDR_W'(OFF_EN)   + ADDR_W'(4 * b)) rdata_o = en[b*REG_W +: REG_W];
                if (addr_i == ADDR_W'(OFF_MSK)  + ADDR_W'(4 * b)) rdata_o = msk[b*REG_W +: REG_W];
            end
        end
    end

    AST_IRQ_FOLLOWS_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(vec_found));  // R4
    AST_VEC_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_found |-> act[vec_idx]);  // R5
    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vec_found |-> (act & ((NSRC'(1) << vec_idx) - NSRC'(1))) == '0);  // R5
    AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_found |-> vec_idx == '0);  // R5
endmodule

// File: tb/tb_birq_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_birq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;
    int          checks = 0;
    int          errors = 0;

    birq_top dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 3; k++) begin
            rd(8'h40 + 8'(4 * k), v); chk("R1 enable", v, 0);
            rd(8'h50 + 8'(4 * k), v); chk("R1 mask", v, 0);
        end
        rd(8'h08, v); chk("R1 prot", v, 0);
        rd(8'h0C, v); chk("R1 trig", v, 0);
        rd(8'h00, v); chk("R1 vector", v, 0);
        chk("R1 irq", 32'(irq_o), 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        step(); src_i[37] = 1'b1;
        rd(8'h14, v); chk("R3 R2 pend bank1", v, 32'h20);
        step(); chk("R4 not enabled", 32'(irq_o), 0);
        wr(8'h44, 32'h20);
        chk("R4 one cycle later", 32'(irq_o), 0);
        step(); chk("R4 irq up", 32'(irq_o), 1);
        rd(8'h00, v); chk("R5 vector 37", v, 37 << 2);
        wr(8'h54, 32'h20); step();
        chk("R4 masked", 32'(irq_o), 0);
        rd(8'h00, v); chk("R5 masked vector", v, 0);
        wr(8'h54, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R3 w1c ignored", v, 32'h20);
        src_i[37] = 1'b0;
        rd(8'h14, v); chk("R3 follows drop", v, 0);
        step(); chk("R4 irq down", 32'(irq_o), 0);
        wr(8'h44, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(8'h44, 32'hFFFF_FFFF); wr(8'h48, 32'hFFFF_FFFF);
        step(); src_i[70] = 1'b1; src_i[40] = 1'b1;
        rd(8'h00, v); chk("R5 lowest wins", v, 40 << 2);
        wr(8'h54, 32'h100);
        rd(8'h00, v); chk("R5 next after mask", v, 70 << 2);
        step(); src_i[70] = 1'b0; src_i[40] = 1'b0;
        wr(8'h54, 32'h0); wr(8'h44, 32'h0); wr(8'h48, 32'h0);
    endtask

    task automatic t_src0();
        logic [31:0] v;
        wr(8'h0C, 32'd3);
        step(); src_i[0] = 1'b0;
        step(); src_i[0] = 1'b1;
        step(); rd(8'h10, v); chk("R6 rise sets", v & 1, 1);
        src_i[0] = 1'b0;
        step(); step(); rd(8'h10, v); chk("R6 rise held", v & 1, 1);
        wr(8'h40, 32'h1); step();
        chk("R4 src0 irq", 32'(irq_o), 1);
        rd(8'h00, v); chk("R5 src0 vector zero", v, 0);
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R7 zero write", v & 1, 1);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R7 ack clears", v & 1, 0);
        // falling edge coinciding with acknowledge
        wr(8'h0C, 32'd2);
        step(); src_i[0] = 1'b1;
        step();
        src_i[0] = 1'b0; wr_en_i = 1'b1; addr_i = 8'h10; wdata_i = 32'h1;
        step(); wr_en_i = 1'b0;
        rd(8'h10, v); chk("R7 R6 fall beats ack", v & 1, 1);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R7 ack after fall", v & 1, 0);
        // high level with ack while still high
        wr(8'h0C, 32'd1);
        step(); src_i[0] = 1'b1;
        step(); rd(8'h10, v); chk("R6 high sets", v & 1, 1);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R7 high ack held", v & 1, 1);
        step(); src_i[0] = 1'b1;
        wr(8'h0C, 32'd0);
        step(); src_i[0] = 1'b0;
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R6 low level held", v & 1, 1);
        step(); src_i[0] = 1'b1;
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R7 low ack", v & 1, 0);
        wr(8'h40, 32'h0);
    endtask

    task automatic t_ctrl_regs();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R8 prot set", v, 1);
        wr(8'h08, 32'h0);
        rd(8'h08, v); chk("R8 prot clear", v, 0);
        wr(8'h0C, 32'hFFFF_FFFC);
        rd(8'h0C, v); chk("R8 trig field", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h40, 32'h0000_00F0);
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R9 enable untouched", v, 32'hF0);
        rd(8'h4C, v); chk("R9 unmapped read", v, 0);
        rd(8'h41, v); chk("R9 misaligned read", v, 0);
        rd(8'h60, v); chk("R9 far read", v, 0);
        rd(8'h08, v); chk("R9 prot untouched", v, 0);
        rd(8'h00, v); chk("R9 vector", v, 0);
        wr(8'h40, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        src_i[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq_o), 0);
        rst_n = 1'b1;
        step();
        t_reset();
        t_level();
        t_priority();
        t_src0();
        t_ctrl_regs();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule